// File: doc/BRIEF.md
# Receive Descriptor Queue Pointer Register

This block is one memory-mapped register of a network controller. It holds two things. The first is the start address of the list of receive buffer descriptors. The second is the live pointer that the receive DMA engine uses to walk that list. Software programs the start address and a queue-off flag through a simple 32-bit register bus, and must do so while reception is switched off. While the receive-enable input is high, every write to the register is silently dropped.

Once reception runs, the receive engine pulses a consumed strobe each time it finishes with a descriptor. The pointer then moves forward by one descriptor, which is 8 bytes. If a wrap strobe comes with the pulse, the pointer returns to the stored start address instead.

A read of the register does not return the value that was written. It returns the descriptor address currently in use, together with the queue-off flag. The live pointer and the flag are also driven out on dedicated ports for the DMA engine.

Top module: `rxDescQueuePtr`

## Requirements
- R1: After reset the start address, the live pointer and the queue-off flag are all zero, and a read at the register offset returns 0x00000000.
- R2: A write at byte offset 0x018 while rxEnable is low does three things in one cycle. It stores wrData[31:2] as the start address, loads the same value into the live pointer, and stores wrData[0] as the queue-off flag.
- R3: A write at offset 0x018 while rxEnable is high changes neither the address nor the queue-off flag.
- R4: A descConsumed pulse with descWrap low, while rxEnable is high and the queue-off flag is 0, adds 8 to the live pointer. The addition wraps modulo 2^32.
- R5: A descConsumed pulse with descWrap high, under the same conditions as R4, reloads the live pointer from the stored start address.
- R6: A descConsumed pulse leaves the live pointer unchanged in two cases: while the queue-off flag is 1, or while rxEnable is low.
- R7: Reads of the register at offset 0x018 are laid out as follows:
  - bits 31:2 hold the live pointer address;
  - bit 1 always reads 0, and writes to it are discarded;
  - bit 0 holds the queue-off flag, where 1 means the queue is off.
- R8: Writes to any other offset change nothing, and reads at any other offset, or with rdEn low, return zero.
- R9: With the 64-bit datapath setting (the default), bit 2 of the written address is discarded. This keeps the pointer 8-byte aligned.
- R10: The descPtr output always equals the live pointer address, with its two low bits zero. The queueOff output always equals the queue-off flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte offset of the register access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (combinational) |
| rxEnable | input | 1 | Receive enable from the network control register |
| descConsumed | input | 1 | One-cycle pulse: a descriptor has been used |
| descWrap | input | 1 | Qualifies descConsumed: go back to the start address |
| descPtr | output | 32 | Live descriptor address for the DMA engine |
| queueOff | output | 1 | Queue-off flag |

## Verification
The hardest situation to reach is a consumed pulse that arrives while reception runs but the queue is off. The flag cannot be written while rxEnable is high, so the bench first writes the flag with reception off and only then raises rxEnable before pulsing. The same ordering is needed to probe the wrap reload: the bench advances the pointer several steps under reception, so that a return to the start address can be told apart from a plain step, and then sends the wrap pulse. Rollover at the top of the address space is reached by programming a start address of 0xFFFFFFF8 and advancing once.

// File: rtl/rxqPkg.sv
package rxqPkg;
  typedef struct packed {
    logic loadBase;
    logic stepPtr;
    logic reloadPtr;
  } ctlStrobe_t;
endpackage

// File: rtl/rxqCtl.sv
module rxqCtl
  import rxqPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rxEnable,
  input  logic              descConsumed,
  input  logic              descWrap,
  input  logic              queueOffQ,
  output logic              addrHit,
  output ctlStrobe_t        strb
);
  logic advanceOk;

  always_comb begin
    addrHit        = (regAddr == REG_OFF);
    advanceOk      = descConsumed && rxEnable && !queueOffQ;
    strb.loadBase  = wrEn && addrHit && !rxEnable;
    strb.stepPtr   = advanceOk && !descWrap;
    strb.reloadPtr = advanceOk && descWrap;
  end

  // R3: writes are locked out while receive is enabled
  a_r3_no_load_rx_on: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable |-> !strb.loadBase);
  // R6: no pointer motion while the queue is off or receive is disabled
  a_r6_no_move_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (queueOffQ || !rxEnable) |-> !(strb.stepPtr || strb.reloadPtr));
  a_r5_one_move: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.stepPtr && strb.reloadPtr));
endmodule

// File: rtl/rxqPath.sv
module rxqPath
  import rxqPkg::*;
#(
  parameter int DESC_BYTES = 8,
  parameter bit DP64       = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  strb,
  input  logic [31:0] wrData,
  output logic [29:0] ptrWord,
  output logic [29:0] baseWord,
  output logic        queueOffQ
);
  localparam int          STEP_WORDS = DESC_BYTES / 4;
  localparam logic [29:0] STEP_VAL   = 30'(STEP_WORDS);

  logic [29:0] wrWord;

  generate
    if (DP64) begin : g_align64
      assign wrWord = {wrData[31:3], 1'b0};
    end else begin : g_align32
      assign wrWord = wrData[31:2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrWord   <= '0;
      baseWord  <= '0;
      queueOffQ <= 1'b0;
    end else if (strb.loadBase) begin
      baseWord  <= wrWord;
      ptrWord   <= wrWord;
      queueOffQ <= wrData[0];
    end else if (strb.reloadPtr) begin
      ptrWord <= baseWord;
    end else if (strb.stepPtr) begin
      ptrWord <= ptrWord + STEP_VAL;
    end
  end

  // R2: an accepted write sets the live pointer to the new start address
  a_r2_load_ptr: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBase |=> (ptrWord == baseWord));
  // R4: a step adds one descriptor
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepPtr && !strb.loadBase) |=> (ptrWord == $past(ptrWord) + STEP_VAL));
  // R5: a wrap goes back to the stored start address
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reloadPtr && !strb.loadBase) |=> (ptrWord == $past(baseWord)));
  a_r3_base_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadBase |=> $stable(baseWord) && $stable(queueOffQ));

  generate
    if (DP64) begin : g_chk64
      // R9: pointer stays 8-byte aligned
      a_r9_align: assert property (@(posedge clk) disable iff (!rstN)
        ptrWord[0] == 1'b0);
    end
  endgenerate
endmodule

// File: rtl/rxDescQueuePtr.sv
module rxDescQueuePtr
  import rxqPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'h18,
  parameter int DESC_BYTES = 8,
  parameter bit DP64 = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              rxEnable,
  input  logic              descConsumed,
  input  logic              descWrap,
  output logic [31:0]       descPtr,
  output logic              queueOff
);
  ctlStrobe_t  strb;
  logic        addrHit;
  logic        queueOffQ;
  logic [29:0] ptrWord;
  logic [29:0] baseWord;

  rxqCtl #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .rxEnable(rxEnable), .descConsumed(descConsumed), .descWrap(descWrap),
    .queueOffQ(queueOffQ), .addrHit(addrHit), .strb(strb)
  );

  rxqPath #(.DESC_BYTES(DESC_BYTES), .DP64(DP64)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .ptrWord(ptrWord), .baseWord(baseWord), .queueOffQ(queueOffQ)
  );

  always_comb begin
    descPtr  = {ptrWord, 2'b00};
    queueOff = queueOffQ;
    rdData   = (rdEn && addrHit) ? {ptrWord, 1'b0, queueOffQ} : 32'h0;
  end

  // R7: bit 1 of read data is always zero
  a_r7_bit1_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[1] == 1'b0);
  // R8: no read data unless the register is addressed
  a_r8_quiet_read: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && addrHit) |-> (rdData == 32'h0));
endmodule

// File: tb/tb_rxDescQueuePtr.sv
module tb_rxDescQueuePtr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        rxEnable = 1'b0;
  logic        descConsumed = 1'b0;
  logic        descWrap = 1'b0;
  logic [31:0] descPtr;
  logic        queueOff;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  rxDescQueuePtr dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .rxEnable(rxEnable),
    .descConsumed(descConsumed), .descWrap(descWrap),
    .descPtr(descPtr), .queueOff(queueOff)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard away from the edge
  always @(negedge clk) begin
    if (rdEn) begin
      if (expQ.size() == 0) check("scoreboard-empty", 32'h1, 32'h0);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic regRead(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    expQ.push_back(exp); tagQ.push_back(tag);
    rdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic consume(input logic wrap);
    @(posedge clk); #1;
    descConsumed = 1'b1; descWrap = wrap;
    @(posedge clk); #1;
    descConsumed = 1'b0; descWrap = 1'b0;
  endtask

  task automatic setRx(input logic v);
    @(posedge clk); #1;
    rxEnable = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++; testsRun++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    regRead("R1 reset read", 8'h18, 32'h0);
    #1 check("R1 reset descPtr", descPtr, 32'h0);
    check("R1 reset queueOff", {31'h0, queueOff}, 32'h0);

    // R2/R7: bit1 discarded, flag set, bit2 zero already
    regWrite(8'h18, 32'h1000_0103);
    regRead("R7 bit1 zero flag one", 8'h18, 32'h1000_0101);
    #1 check("R10 queueOff out", {31'h0, queueOff}, 32'h1);
    // R6: consume with receive off
    consume(1'b0);
    regRead("R6 rx off no move", 8'h18, 32'h1000_0101);

    regWrite(8'h18, 32'h2000_0040);
    regRead("R2 write loads ptr", 8'h18, 32'h2000_0040);

    // R8: other offset
    regWrite(8'h1C, 32'hFFFF_0000);
    regRead("R8 other write ignored", 8'h18, 32'h2000_0040);
    regRead("R8 other read zero", 8'h1C, 32'h0);
    #1 check("R8 rdEn low zero", rdData, 32'h0);

    // R9: bit 2 dropped
    regWrite(8'h18, 32'h3000_0004);
    regRead("R9 align", 8'h18, 32'h3000_0000);
    regWrite(8'h18, 32'h2000_0040);

    setRx(1'b1);
    consume(1'b0); consume(1'b0); consume(1'b0);
    regRead("R4 three steps", 8'h18, 32'h2000_0058);
    #1 check("R10 descPtr", descPtr, 32'h2000_0058);

    regWrite(8'h18, 32'h5555_0001);
    regRead("R3 write locked", 8'h18, 32'h2000_0058);
    #1 check("R3 flag locked", {31'h0, queueOff}, 32'h0);

    consume(1'b1);
    regRead("R5 wrap to base", 8'h18, 32'h2000_0040);
    consume(1'b0);
    regRead("R4 step after wrap", 8'h18, 32'h2000_0048);

    setRx(1'b0);
    regWrite(8'h18, 32'h4000_0001);
    setRx(1'b1);
    consume(1'b0); consume(1'b1);
    regRead("R6 queue off no move", 8'h18, 32'h4000_0001);
    #1 check("R10 descPtr queue off", descPtr, 32'h4000_0000);

    setRx(1'b0);
    regWrite(8'h18, 32'hFFFF_FFF8);
    setRx(1'b1);
    consume(1'b0);
    regRead("R4 rollover", 8'h18, 32'h0000_0000);
    consume(1'b1);
    regRead("R5 wrap after rollover", 8'h18, 32'hFFFF_FFF8);

    repeat (2) @(posedge clk);
    #1 check("scoreboard drained", 32'(expQ.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule